// File: doc/BRIEF.md
# Multi-Synthesizer Synchronization Sequencer

This block is the controller that brings several frequency synthesizer devices into one known phase relationship. On a start request it holds a shared reset line high for a fixed number of reference clock cycles. It then writes a small, generated list of register commands over a shared address and data bus. Each device has its own active-low write strobe. The sequence ends with one update pulse that all devices see on the same reference clock edge, so every device commits its new settings together.

Two modes are supported. In direct mode the sequencer configures each device, loads each device's frequency word and a zero phase offset, and then issues the single common update. In multiplier mode the configuration also turns on the devices' clock multipliers. An update is then issued to apply that setting, and a parameterized lock wait follows. During that wait the tuning words are still zero from reset, because no frequency write has been made. The mode, multiplier ratio and frequency words are captured when start is accepted.

The command list is computed, not stored. Configuration writes the update-source register (address A_UPD, value 0x01 = external update) and the clock register (address A_CLK, value {enable, ratio} with the enable at bit MULT_W). Loading writes the clock register again with the same value, then the frequency bytes, then the phase bytes. Devices are always served in index order, and all of one device's writes come before the next device's.

Top module: `sync_sequencer`

## Requirements
- R1: A start pulse while idle makes busy high from the next cycle. A start pulse while busy is ignored: the sequence in progress, its captured mode, ratio and frequency words, and its number of reset pulses stay as they were.
- R2: Each sequence drives dev_reset high once, for exactly RST_CYCLES cycles (at least 10), before any write strobe.
- R3: Configuration writes come first, for devices 0 to N_DEV-1 in order. Each device gets two writes: address A_UPD with data 0x01, then address A_CLK with data {mult_mode, mult_ratio}, where the enable bit sits at position MULT_W.
- R4: In multiplier mode (mult_mode=1), one update pulse follows the configuration writes. No write strobe occurs until at least LOCK_CYCLES cycles after that pulse ends, so no frequency word is written during the lock wait.
- R5: Load writes come per device in index order. Each device gets: A_CLK with the same {mult_mode, mult_ratio} byte; then its FTW_BYTES frequency bytes, most significant first, at A_FTW+k; then PH_BYTES zero bytes at A_PH+k. Device d's word is ftw_in[d*FTW_W +: FTW_W].
- R6: Write strobes are active low and never more than one is low at a time. Each strobe is low for exactly one cycle. bus_addr and bus_data hold the same values in the cycle before, during and after the strobe.
- R7: io_update is never high while a strobe is low, and no update falls between load writes. After the last load write, one common update is driven through a register. Every update pulse is high for exactly UPD_CYCLES cycles.
- R8: done is high for one cycle after the final update pulse has ended, and busy is low in the following cycle.
- R9: Each sequence produces exactly one update pulse in direct mode and exactly two in multiplier mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| mult_mode | input | 1 | 1 = clock multiplier mode |
| mult_ratio | input | MULT_W | Multiplier ratio written to the clock register |
| ftw_in | input | N_DEV*FTW_BYTES*DATA_W | Frequency words, device 0 in the low bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_reset | output | 1 | Common device reset, active high |
| bus_addr | output | ADDR_W | Shared register address |
| bus_data | output | DATA_W | Shared write data |
| wr_n | output | N_DEV | Per-device write strobes, active low |
| io_update | output | 1 | Common registered update pulse |

## Verification
The assertions assume three things about the inputs. rst_n is released with start low. The mode, ratio and frequency inputs only matter in the cycle in which start is accepted. Devices respond only to the strobes, so no input constrains the timing of the bus. The bench changes its inputs on the falling clock edge, holds start for one cycle at a time, and waits for done before it starts the next sequence. Its only deliberate breach is a second start, with inverted mode, ratio and words, during a running sequence; this is the case R1 says must have no effect. It runs both modes across all-zero, all-one, alternating and distinct per-device frequency patterns and several ratios.

// File: rtl/sync_seq_pkg.sv
package sync_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RST,
      S_CFG,
      S_FIRE,
      S_UWAIT,
      S_LOCK,
      S_LOAD,
      S_DONE
   } seq_state_t;

   typedef enum logic {
      STG_CFG,
      STG_LOAD
   } stage_t;

endpackage

// File: rtl/sync_seq_cmdgen.sv
module sync_seq_cmdgen
   import sync_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 6,
   parameter int FTW_BYTES = 6,
   parameter int PH_BYTES  = 2,
   parameter int MULT_W    = 5,
   parameter int A_UPD     = 'h1F,
   parameter int A_CLK     = 'h1E,
   parameter int A_FTW     = 'h04,
   parameter int A_PH      = 'h0C,
   parameter int CIDX_W    = 3
) (
   input  stage_t                      stage,
   input  logic [CIDX_W-1:0]           idx,
   input  logic [FTW_BYTES*DATA_W-1:0] ftw,
   input  logic                        mult_en,
   input  logic [MULT_W-1:0]           ratio,
   output logic [ADDR_W-1:0]           cmd_addr,
   output logic [DATA_W-1:0]           cmd_data,
   output logic                        cmd_last
);

   localparam int CFG_N  = 2;
   localparam int LOAD_N = 1 + FTW_BYTES + PH_BYTES;

   logic [DATA_W-1:0] ftw_byte [FTW_BYTES];
   logic [DATA_W-1:0] clk_word;

   // byte 0 is the most significant byte of the word
   for (genvar k = 0; k < FTW_BYTES; k++) begin : g_byte
      assign ftw_byte[k] = ftw[(FTW_BYTES-1-k)*DATA_W +: DATA_W];
   end

   assign clk_word = {{(DATA_W-MULT_W-1){1'b0}}, mult_en, ratio};

   always_comb begin
      int k;
      k        = int'(idx);
      cmd_addr = '0;
      cmd_data = '0;
      cmd_last = 1'b0;
      if (stage == STG_CFG) begin
         cmd_last = (k == CFG_N-1);
         if (k == 0) begin
            cmd_addr = ADDR_W'(A_UPD);
            cmd_data = DATA_W'(1);
         end else begin
            cmd_addr = ADDR_W'(A_CLK);
            cmd_data = clk_word;
         end
      end else begin
         cmd_last = (k == LOAD_N-1);
         if (k == 0) begin
            cmd_addr = ADDR_W'(A_CLK);
            cmd_data = clk_word;
         end else if (k <= FTW_BYTES) begin
            cmd_addr = ADDR_W'(A_FTW + k - 1);
            for (int j = 0; j < FTW_BYTES; j++) begin
               if (k - 1 == j) cmd_data = ftw_byte[j];
            end
         end else begin
            cmd_addr = ADDR_W'(A_PH + k - 1 - FTW_BYTES);
            cmd_data = '0;
         end
      end
   end

endmodule

// File: rtl/sync_seq_busdrv.sv
module sync_seq_busdrv #(
   parameter int N_DEV  = 2,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int DEV_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [DEV_W-1:0]  dev,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              ack,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic [N_DEV-1:0]  wr_n
);

   localparam logic [N_DEV-1:0] ALL_HI = '1;

   // three cycles per write: setup, strobe, hold
   logic [1:0]       ph;
   logic [N_DEV-1:0] strobe_nxt;

   for (genvar i = 0; i < N_DEV; i++) begin : g_strobe
      assign strobe_nxt[i] = !(req && ph == 2'd1 && dev == DEV_W'(i));
   end

   assign ack = req && ph == 2'd2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= 2'd0;
         bus_addr <= '0;
         bus_data <= '0;
         wr_n     <= ALL_HI;
      end else begin
         if (req) ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
         else     ph <= 2'd0;
         if (req && ph == 2'd0) begin
            bus_addr <= addr;
            bus_data <= data;
         end
         wr_n <= strobe_nxt;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~wr_n)); // R6

   AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n != ALL_HI) |=> (wr_n == ALL_HI)); // R6

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n == ALL_HI && $past(wr_n) != ALL_HI) |-> ($stable(bus_addr) && $stable(bus_data))); // R6

endmodule

// File: rtl/sync_seq_updpulse.sv
module sync_seq_updpulse #(
   parameter int UPD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic upd_out,
   output logic active
);

   localparam int CNT_W = $clog2(UPD_CYCLES + 1);

   logic upd_lvl;

   if (UPD_CYCLES == 1) begin : g_single
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= fire;
      end
      assign upd_lvl = lvl_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (fire)       cnt <= CNT_W'(UPD_CYCLES);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign upd_lvl = (cnt != '0);
   end

   // retiming register on the reference clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_out <= 1'b0;
      else        upd_out <= upd_lvl;
   end

   assign active = upd_lvl || upd_out;

   logic [CNT_W:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (upd_out) hi_cnt <= hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   AST_UPD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_out) |-> (hi_cnt == (CNT_W+1)'(UPD_CYCLES))); // R7

endmodule

// File: rtl/sync_sequencer.sv
module sync_sequencer
   import sync_seq_pkg::*;
#(
   parameter int N_DEV       = 2,
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int FTW_BYTES   = 6,
   parameter int PH_BYTES    = 2,
   parameter int MULT_W      = 5,
   parameter int RST_CYCLES  = 10,
   parameter int CLK_HZ      = 125_000_000,
   parameter int LOCK_CYCLES = CLK_HZ / 1000,
   parameter int UPD_CYCLES  = 4,
   parameter int A_UPD       = 'h1F,
   parameter int A_CLK       = 'h1E,
   parameter int A_FTW       = 'h04,
   parameter int A_PH        = 'h0C
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic                              mult_mode,
   input  logic [MULT_W-1:0]                 mult_ratio,
   input  logic [N_DEV*FTW_BYTES*DATA_W-1:0] ftw_in,
   output logic                              busy,
   output logic                              done,
   output logic                              dev_reset,
   output logic [ADDR_W-1:0]                 bus_addr,
   output logic [DATA_W-1:0]                 bus_data,
   output logic [N_DEV-1:0]                  wr_n,
   output logic                              io_update
);

   localparam int FTW_W   = FTW_BYTES * DATA_W;
   localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1;
   localparam int LOAD_N  = 1 + FTW_BYTES + PH_BYTES;
   localparam int CIDX_W  = $clog2(LOAD_N + 1);
   localparam int TMR_MAX = (LOCK_CYCLES > RST_CYCLES) ? LOCK_CYCLES : RST_CYCLES;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [N_DEV-1:0] ALL_HI = '1;

   if (RST_CYCLES < 10) begin : g_chk_rst
      $error("RST_CYCLES must be at least 10");
   end
   if (N_DEV < 2) begin : g_chk_dev
      $error("N_DEV must be at least 2");
   end
   if (DATA_W < MULT_W + 2) begin : g_chk_mult
      $error("DATA_W too narrow for clock word");
   end
   if (UPD_CYCLES < 1 || LOCK_CYCLES < 1) begin : g_chk_time
      $error("UPD_CYCLES and LOCK_CYCLES must be positive");
   end
   if (A_FTW + FTW_BYTES > A_PH || A_PH + PH_BYTES > A_CLK || A_CLK >= A_UPD
       || A_UPD >= (1 << ADDR_W)) begin : g_chk_map
      $error("register addresses overlap or exceed ADDR_W");
   end

   seq_state_t          state, state_nxt;
   logic [TMR_W-1:0]    tmr;
   logic [DEV_W-1:0]    dev_idx;
   logic [CIDX_W-1:0]   cmd_idx;
   logic                final_q;
   logic                mode_q;
   logic [MULT_W-1:0]   ratio_q;
   logic [N_DEV*FTW_W-1:0] ftw_q;
   logic [FTW_W-1:0]    dev_ftw;
   logic [ADDR_W-1:0]   cmd_addr;
   logic [DATA_W-1:0]   cmd_data;
   logic                cmd_last;
   logic                dev_last;
   logic                wr_req, wr_ack;
   logic                upd_fire, upd_active;
   stage_t              stage;

   assign dev_last = (dev_idx == DEV_W'(N_DEV-1));
   assign wr_req   = (state == S_CFG) || (state == S_LOAD);
   assign stage    = (state == S_LOAD) ? STG_LOAD : STG_CFG;
   assign upd_fire = (state == S_FIRE);
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_DONE);

   always_comb begin
      dev_ftw = '0;
      for (int j = 0; j < N_DEV; j++) begin
         if (dev_idx == DEV_W'(j)) dev_ftw = ftw_q[j*FTW_W +: FTW_W];
      end
   end

   always_comb begin
      state_nxt = state;
      unique case (state)
         S_IDLE:  if (start) state_nxt = S_RST;
         S_RST:   if (tmr == TMR_W'(RST_CYCLES-1)) state_nxt = S_CFG;
         S_CFG:   if (wr_ack && cmd_last && dev_last) state_nxt = mode_q ? S_FIRE : S_LOAD;
         S_FIRE:  state_nxt = S_UWAIT;
         S_UWAIT: if (!upd_active) state_nxt = final_q ? S_DONE : S_LOCK;
         S_LOCK:  if (tmr == TMR_W'(LOCK_CYCLES-1)) state_nxt = S_LOAD;
         S_LOAD:  if (wr_ack && cmd_last && dev_last) state_nxt = S_FIRE;
         S_DONE:  state_nxt = S_IDLE;
         default: state_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         tmr       <= '0;
         dev_idx   <= '0;
         cmd_idx   <= '0;
         final_q   <= 1'b0;
         mode_q    <= 1'b0;
         ratio_q   <= '0;
         ftw_q     <= '0;
         dev_reset <= 1'b0;
      end else begin
         state     <= state_nxt;
         dev_reset <= (state_nxt == S_RST);
         if (state_nxt != state)                   tmr <= '0;
         else if (state == S_RST || state == S_LOCK) tmr <= tmr + 1'b1;
         if (state == S_IDLE && start) begin
            mode_q  <= mult_mode;
            ratio_q <= mult_ratio;
            ftw_q   <= ftw_in;
            final_q <= 1'b0;
            dev_idx <= '0;
            cmd_idx <= '0;
         end
         if (wr_ack) begin
            if (cmd_last) begin
               cmd_idx <= '0;
               dev_idx <= dev_last ? '0 : dev_idx + 1'b1;
            end else begin
               cmd_idx <= cmd_idx + 1'b1;
            end
         end
         if (state == S_LOAD && state_nxt == S_FIRE) final_q <= 1'b1;
      end
   end

   sync_seq_cmdgen #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FTW_BYTES(FTW_BYTES), .PH_BYTES(PH_BYTES),
      .MULT_W(MULT_W), .A_UPD(A_UPD), .A_CLK(A_CLK), .A_FTW(A_FTW), .A_PH(A_PH),
      .CIDX_W(CIDX_W)
   ) u_cmd (
      .stage(stage), .idx(cmd_idx), .ftw(dev_ftw), .mult_en(mode_q), .ratio(ratio_q),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
   );

   sync_seq_busdrv #(
      .N_DEV(N_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_W(DEV_W)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .req(wr_req), .dev(dev_idx), .addr(cmd_addr),
      .data(cmd_data), .ack(wr_ack), .bus_addr(bus_addr), .bus_data(bus_data), .wr_n(wr_n)
   );

   sync_seq_updpulse #(
      .UPD_CYCLES(UPD_CYCLES)
   ) u_upd (
      .clk(clk), .rst_n(rst_n), .fire(upd_fire), .upd_out(io_update), .active(upd_active)
   );

   logic [TMR_W-1:0] rst_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rst_hi_cnt <= '0;
      else if (dev_reset) rst_hi_cnt <= rst_hi_cnt + 1'b1;
      else                rst_hi_cnt <= '0;
   end

   AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_reset) |-> (rst_hi_cnt == TMR_W'(RST_CYCLES))); // R2

   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset |-> (wr_n == ALL_HI && !io_update)); // R2

   AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_LOCK) |-> (wr_n == ALL_HI)); // R4

   AST_NO_UPD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_update && wr_n != ALL_HI)); // R7

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(mode_q) && $stable(ratio_q) && $stable(ftw_q))); // R1

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy)); // R8

endmodule

// File: tb/tb_sync_sequencer.sv
module tb_sync_sequencer;

   localparam int NDEV = 3;
   localparam int LOCK = 40;
   localparam int UPDW = 3;
   localparam int RSTW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mult_mode = 1'b0;
   logic [4:0]  mult_ratio = '0;
   logic [47:0] ftw_in = '0;
   logic        busy, done, dev_reset, io_update;
   logic [5:0]  bus_addr;
   logic [7:0]  bus_data;
   logic [2:0]  wr_n;

   always #4 clk = ~clk;

   sync_sequencer #(
      .N_DEV(NDEV), .ADDR_W(6), .DATA_W(8), .FTW_BYTES(2), .PH_BYTES(2), .MULT_W(5),
      .RST_CYCLES(RSTW), .LOCK_CYCLES(LOCK), .UPD_CYCLES(UPDW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mult_mode(mult_mode),
      .mult_ratio(mult_ratio), .ftw_in(ftw_in), .busy(busy), .done(done),
      .dev_reset(dev_reset), .bus_addr(bus_addr), .bus_data(bus_data), .wr_n(wr_n),
      .io_update(io_update)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit fin = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor at the falling edge
   int cyc = 0;
   int log_n = 0, upd_n = 0, rstp_cnt = 0, done_n = 0, done_cyc = 0;
   int multi_err = 0, hold_err = 0, strobe_long = 0, upd_clash = 0;
   int log_val [1024];
   int log_upd [1024];
   int log_cyc [1024];
   int upd_w [64];
   int upd_fall [64];
   int rst_w [64];
   int rst_fall [64];
   int upd_cur = 0, rst_cur = 0;
   bit prev_low = 1'b0;
   logic [5:0] prev_addr = '0;
   logic [7:0] prev_data = '0;

   always @(negedge clk) begin
      int lows, ld;
      cyc = cyc + 1;
      lows = 0;
      ld = 0;
      for (int i = 0; i < NDEV; i++) if (wr_n[i] === 1'b0) begin lows++; ld = i; end
      if (lows > 1) multi_err++;
      if (lows > 0) begin
         log_val[log_n] = ld * 65536 + int'(bus_addr) * 256 + int'(bus_data);
         log_upd[log_n] = upd_n;
         log_cyc[log_n] = cyc;
         log_n++;
         if (prev_low) strobe_long++;
         if (bus_addr != prev_addr || bus_data != prev_data) hold_err++;
         if (io_update) upd_clash++;
      end
      if (prev_low && lows == 0 && (bus_addr != prev_addr || bus_data != prev_data)) hold_err++;
      prev_low = (lows > 0);
      prev_addr = bus_addr;
      prev_data = bus_data;
      if (io_update === 1'b1) upd_cur++;
      else if (upd_cur > 0) begin
         upd_w[upd_n] = upd_cur; upd_fall[upd_n] = cyc; upd_n++; upd_cur = 0;
      end
      if (dev_reset === 1'b1) rst_cur++;
      else if (rst_cur > 0) begin
         rst_w[rstp_cnt] = rst_cur; rst_fall[rstp_cnt] = cyc; rstp_cnt++; rst_cur = 0;
      end
      if (done === 1'b1) begin done_n++; done_cyc = cyc; end
   end

   task automatic run_seq(input bit m, input logic [4:0] r, input logic [47:0] f, input bit inject);
      int b_log, b_upd, b_rst, b_done, b_multi, b_hold, b_long, b_clash;
      int exp_v [32];
      int exp_u [32];
      int k, cw, gap;
      b_log = log_n; b_upd = upd_n; b_rst = rstp_cnt; b_done = done_n;
      b_multi = multi_err; b_hold = hold_err; b_long = strobe_long; b_clash = upd_clash;
      @(negedge clk);
      mult_mode = m; mult_ratio = r; ftw_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
      if (inject) begin
         repeat (30) @(negedge clk);
         mult_mode = ~m; mult_ratio = ~r; ftw_in = ~f; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         mult_mode = m; mult_ratio = r; ftw_in = f;
      end
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", int'({busy, done}), 0);
      chk(done_n - b_done == 1, "R8 done pulse count", done_n - b_done, 1);
      // expected command list: configuration then load
      cw = int'(m) * 32 + int'(r);
      k = 0;
      for (int d = 0; d < NDEV; d++) begin
         exp_v[k] = d * 65536 + 'h1F * 256 + 1;  exp_u[k] = 0; k++;
         exp_v[k] = d * 65536 + 'h1E * 256 + cw; exp_u[k] = 0; k++;
      end
      for (int d = 0; d < NDEV; d++) begin
         exp_v[k] = d * 65536 + 'h1E * 256 + cw; exp_u[k] = int'(m); k++;
         exp_v[k] = d * 65536 + 'h04 * 256 + int'(f[d*16+8 +: 8]); exp_u[k] = int'(m); k++;
         exp_v[k] = d * 65536 + 'h05 * 256 + int'(f[d*16 +: 8]);   exp_u[k] = int'(m); k++;
         exp_v[k] = d * 65536 + 'h0C * 256; exp_u[k] = int'(m); k++;
         exp_v[k] = d * 65536 + 'h0D * 256; exp_u[k] = int'(m); k++;
      end
      chk(log_n - b_log == k, "R1 R3 R5 write count", log_n - b_log, k);
      for (int i = 0; i < k && i < log_n - b_log; i++) begin
         chk(log_val[b_log+i] == exp_v[i], (i < 2*NDEV) ? "R3 config write" : "R5 load write",
             log_val[b_log+i], exp_v[i]);
         chk(log_upd[b_log+i] - b_upd == exp_u[i], "R4 R7 updates before write",
             log_upd[b_log+i] - b_upd, exp_u[i]);
      end
      chk(rstp_cnt - b_rst == 1, "R2 R1 one reset pulse", rstp_cnt - b_rst, 1);
      if (rstp_cnt > b_rst) begin
         chk(rst_w[b_rst] == RSTW, "R2 reset width", rst_w[b_rst], RSTW);
         chk(log_n > b_log && log_cyc[b_log] > rst_fall[b_rst], "R2 reset before writes",
             log_cyc[b_log], rst_fall[b_rst] + 1);
      end
      chk(upd_n - b_upd == int'(m) + 1, "R9 update pulse count", upd_n - b_upd, int'(m) + 1);
      for (int i = b_upd; i < upd_n; i++)
         chk(upd_w[i] == UPDW, "R7 update width", upd_w[i], UPDW);
      if (m && upd_n > b_upd && log_n - b_log > 2*NDEV) begin
         gap = log_cyc[b_log + 2*NDEV] - upd_fall[b_upd];
         chk(gap >= LOCK, "R4 lock wait before first load", gap, LOCK);
      end
      if (upd_n > b_upd && log_n > b_log)
         chk(upd_fall[upd_n-1] > log_cyc[log_n-1], "R7 final update after last load",
             upd_fall[upd_n-1], log_cyc[log_n-1] + 1);
      if (upd_n > b_upd)
         chk(done_cyc >= upd_fall[upd_n-1], "R8 done after final update", done_cyc, upd_fall[upd_n-1]);
      chk(multi_err == b_multi, "R6 single strobe", multi_err - b_multi, 0);
      chk(strobe_long == b_long, "R6 strobe one cycle", strobe_long - b_long, 0);
      chk(hold_err == b_hold, "R6 address and data held", hold_err - b_hold, 0);
      chk(upd_clash == b_clash, "R7 no update during strobe", upd_clash - b_clash, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset idle", int'({busy, done}), 0);
      chk(wr_n == 3'b111, "R6 reset strobes high", int'(wr_n), 7);
      chk(io_update == 1'b0 && dev_reset == 1'b0, "R7 reset outputs low",
          int'({io_update, dev_reset}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_seq(1'b0, 5'h03, 48'h0000_0000_0000, 1'b0);
      run_seq(1'b1, 5'h04, 48'hFFFF_FFFF_FFFF, 1'b0);
      run_seq(1'b0, 5'h1F, 48'h1234_5678_9ABC, 1'b0);
      run_seq(1'b1, 5'h11, 48'hA5A5_5A5A_0F0F, 1'b0);
      run_seq(1'b1, 5'h00, 48'h0001_0002_0003, 1'b1);
      run_seq(1'b0, 5'h0A, 48'hFEDC_BA98_7654, 1'b1);
      run_seq(1'b1, 5'h15, 48'h8001_4002_2004, 1'b0);
      fin = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule